// File: doc/BRIEF.md
# Serial Addressed Register Loader

This block receives configuration words over a three-wire serial write port: a serial clock, a serial data line and a load strobe. Each rising edge of the serial clock pushes one bit, most significant first, into a 22-bit frame register. When the load strobe rises, the upper 20 bits of the frame are copied into one of four configuration registers. The register is chosen by the two bits that were shifted in last. All four registers drive parallel outputs for the downstream logic. There is no read-back path.

The serial pins are treated as asynchronous. The block samples them in its own system clock domain through synchroniser chains and detects their rising edges there. The serial clock must therefore toggle well below the system clock rate, with each level held for at least four system clock cycles. The block has no power-state input, so loading works in every power mode of the rest of the device. The serial port is a plain control interface and has no flow control, so the port carries no valid/ready handshake.

Top module: `sreg_ld_top`

## Requirements
- R1: After reset, all four configuration outputs read zero.
- R2: Each rising edge of `ser_clk_i` shifts `ser_dat_i` into bit 0 of the 22-bit frame, and the older bits move up one place. After 22 bits the first bit sent sits in frame bit 21. The data field is frame bits 21..2 and the address field is frame bits 1..0.
- R3: On a load the data field is written to the register the address selects: 0 to `aux_r_o`, 1 to `aux_n_o`, 2 to `main_r_o`, 3 to `main_n_o`.
- R4: A write happens only on a rising edge of `ser_le_i`. A steady high level, a falling edge, and bits shifted while the strobe is high write nothing.
- R5: On every write, the three registers that are not addressed keep their previous contents.
- R6: If more than 22 bits arrive before a load, only the last 22 bits shifted are used, and no error is reported.
- R7: If fewer than 22 bits arrive before a load, the frame is made of those bits plus the newest bits left from before. A 22-bit frame still results, and no error is reported.
- R8: Each rising edge of the load strobe causes exactly one write, lasting one system clock cycle.
- R9: Shifting goes on at every serial clock edge, whatever the level of `ser_le_i`. The frame changes only on such edges.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ser_clk_i | input | 1 | Serial clock; data is sampled on its rising edge |
| ser_dat_i | input | 1 | Serial data, most significant bit first |
| ser_le_i | input | 1 | Load strobe; a rising edge commits the frame |
| aux_r_o | output | 20 | Configuration register, address 0 |
| aux_n_o | output | 20 | Configuration register, address 1 |
| main_r_o | output | 20 | Configuration register, address 2 |
| main_n_o | output | 20 | Configuration register, address 3 |

## Verification
The hardest case is a frame that is not exactly 22 bits long. It is also hard to reach the frame register while the load strobe is already high, because nothing shows in the outputs until a later strobe edge. The stimulus tracks its own model of the frame. It sends over-long and short bursts, and it shifts whole frames while holding the strobe high. It then checks that the outputs stay unchanged until a fresh rising edge. That edge must commit exactly the bits the model predicts.

// File: rtl/sreg_ld_pkg.sv
package sreg_ld_pkg;
  localparam int DATA_W_DEF = 20;
  localparam int ADDR_W_DEF = 2;

  typedef enum logic [1:0] {
    SEL_AUX_R  = 2'd0,
    SEL_AUX_N  = 2'd1,
    SEL_MAIN_R = 2'd2,
    SEL_MAIN_N = 2'd3
  } reg_sel_e;
endpackage

// File: rtl/sreg_ld_sync.sv
module sreg_ld_sync #(
  parameter int W      = 3,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] async_i,
  output logic [W-1:0] sync_o,
  output logic [W-1:0] rise_o
);
  logic [W-1:0] chain [STAGES];
  logic [W-1:0] prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < STAGES; s++) chain[s] <= '0;
      prev_q <= '0;
    end else begin
      chain[0] <= async_i;
      for (int s = 1; s < STAGES; s++) chain[s] <= chain[s-1];
      prev_q <= chain[STAGES-1];
    end
  end

  assign sync_o = chain[STAGES-1];
  assign rise_o = chain[STAGES-1] & ~prev_q;
endmodule

// File: rtl/sreg_ld_shifter.sv
module sreg_ld_shifter #(
  parameter int FRAME_W = 22
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               shift_en,
  input  logic               bit_i,
  output logic [FRAME_W-1:0] frame_o
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        frame_o <= '0;
    else if (shift_en) frame_o <= {frame_o[FRAME_W-2:0], bit_i};
  end

  // R9: the frame moves only on a detected serial clock edge
  a_r9_frame_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !shift_en |=> $stable(frame_o));
  // R2: the newest bit lands in position 0
  a_r2_lsb_entry: assert property (@(posedge clk) disable iff (!rst_n)
    shift_en |=> frame_o[0] == $past(bit_i));
endmodule

// File: rtl/sreg_ld_bank.sv
module sreg_ld_bank #(
  parameter int DATA_W = 20,
  parameter int ADDR_W = 2,
  localparam int NREG  = 1 << ADDR_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_stb,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  output logic [DATA_W-1:0] regs_o [NREG]
);
  logic [NREG-1:0] we;

  always_comb begin
    we = '0;
    if (wr_stb) we[wr_addr] = 1'b1;
  end

  a_r3_onehot_we: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(we));

  for (genvar k = 0; k < NREG; k++) begin : g_reg
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     regs_o[k] <= '0;
      else if (we[k]) regs_o[k] <= wr_data;
    end

    // R3: addressed register takes the data field
    a_r3_write: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_stb && wr_addr == k) |=> regs_o[k] == $past(wr_data));
    // R5: any other register keeps its contents
    a_r5_keep: assert property (@(posedge clk) disable iff (!rst_n)
      !(wr_stb && wr_addr == k) |=> $stable(regs_o[k]));
  end
endmodule

// File: rtl/sreg_ld_top.sv
module sreg_ld_top
  import sreg_ld_pkg::*;
#(
  parameter int DATA_W      = DATA_W_DEF,
  parameter int ADDR_W      = ADDR_W_DEF,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ser_clk_i,
  input  logic              ser_dat_i,
  input  logic              ser_le_i,
  output logic [DATA_W-1:0] aux_r_o,
  output logic [DATA_W-1:0] aux_n_o,
  output logic [DATA_W-1:0] main_r_o,
  output logic [DATA_W-1:0] main_n_o
);
  localparam int FRAME_W = DATA_W + ADDR_W;
  localparam int NREG    = 1 << ADDR_W;

  logic [2:0]         pins_sync, pins_rise;
  logic [FRAME_W-1:0] frame;
  logic [DATA_W-1:0]  regs [NREG];
  logic               shift_en, load_stb;

  sreg_ld_sync #(.W(3), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n),
    .async_i({ser_le_i, ser_dat_i, ser_clk_i}),
    .sync_o(pins_sync), .rise_o(pins_rise)
  );

  assign shift_en = pins_rise[0];
  assign load_stb = pins_rise[2];

  sreg_ld_shifter #(.FRAME_W(FRAME_W)) u_shift (
    .clk(clk), .rst_n(rst_n), .shift_en(shift_en),
    .bit_i(pins_sync[1]), .frame_o(frame)
  );

  sreg_ld_bank #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_bank (
    .clk(clk), .rst_n(rst_n), .wr_stb(load_stb),
    .wr_addr(frame[ADDR_W-1:0]), .wr_data(frame[FRAME_W-1:ADDR_W]),
    .regs_o(regs)
  );

  assign aux_r_o  = regs[SEL_AUX_R];
  assign aux_n_o  = regs[SEL_AUX_N];
  assign main_r_o = regs[SEL_MAIN_R];
  assign main_n_o = regs[SEL_MAIN_N];

  // R8: one write pulse per rising load edge
  a_r8_single_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    load_stb |=> !load_stb);
  // R4: a write needs the synchronised strobe to have just risen
  a_r4_edge_only: assert property (@(posedge clk) disable iff (!rst_n)
    load_stb |-> pins_sync[2]);
endmodule

// File: tb/sreg_ld_top_bench.sv
module sreg_ld_top_bench;
  logic clk = 0, rst_n = 0;
  logic ser_clk = 0, ser_dat = 0, ser_le = 0;
  logic [19:0] aux_r, aux_n, main_r, main_n;
  logic [21:0] mdl_frame = '0;
  logic [19:0] exp_r [4];
  int checks = 0, failures = 0;

  always #2.5 clk = ~clk;

  sreg_ld_top u_sreg_ld_top (
    .clk(clk), .rst_n(rst_n), .ser_clk_i(ser_clk), .ser_dat_i(ser_dat),
    .ser_le_i(ser_le), .aux_r_o(aux_r), .aux_n_o(aux_n),
    .main_r_o(main_r), .main_n_o(main_n)
  );

  function automatic logic [19:0] actual(int k);
    case (k)
      0: return aux_r;
      1: return aux_n;
      2: return main_r;
      default: return main_n;
    endcase
  endfunction

  task automatic wait_clk(int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic check_all(string req);
    @(negedge clk);
    for (int k = 0; k < 4; k++) begin
      checks++;
      if (actual(k) !== exp_r[k]) begin
        failures++;
        $display("FAIL %s reg%0d actual=%h expected=%h", req, k, actual(k), exp_r[k]);
      end
    end
  endtask

  task automatic send_bit(logic b);
    ser_dat = b;
    wait_clk(4);
    ser_clk = 1;
    mdl_frame = {mdl_frame[20:0], b};
    wait_clk(4);
    ser_clk = 0;
    wait_clk(1);
  endtask

  task automatic send_bits(logic [31:0] v, int n);
    for (int i = n - 1; i >= 0; i--) send_bit(v[i]);
  endtask

  task automatic le_rise();
    ser_le = 1;
    exp_r[mdl_frame[1:0]] = mdl_frame[21:2];
    wait_clk(8);
  endtask

  task automatic le_fall();
    ser_le = 0;
    wait_clk(6);
  endtask

  task automatic load_frame(logic [19:0] d, logic [1:0] a);
    send_bits({10'b0, d, a}, 22);
    le_rise();
    le_fall();
  endtask

  task automatic t_reset();
    check_all("R1");
  endtask

  task automatic t_each_addr();
    load_frame(20'hA5C3E, 2'd0); check_all("R3 R5 aux_r");
    load_frame(20'h1B2C4, 2'd1); check_all("R3 R5 aux_n");
    load_frame(20'h7F00D, 2'd2); check_all("R3 R5 main_r");
    load_frame(20'hC0FFE, 2'd3); check_all("R3 R5 main_n");
  endtask

  task automatic t_bit_order();
    load_frame(20'h80001, 2'd3); check_all("R2 msb first");
    load_frame(20'hFFFFF, 2'd2); check_all("R2 all ones");
    load_frame(20'h00000, 2'd2); check_all("R2 all zeros");
  endtask

  task automatic t_overlong();
    send_bits(32'h1F, 5);
    load_frame(20'h3C3C3, 2'd1);
    check_all("R6 overlong");
  endtask

  task automatic t_short();
    send_bits(32'hB6, 8);
    le_rise(); le_fall();
    check_all("R7 short burst");
  endtask

  task automatic t_le_level();
    le_rise();
    check_all("R8 write at edge");
    send_bits({10'b0, 20'h55AA5, 2'd0}, 22);
    check_all("R4 R9 shift while high");
    le_fall();
    check_all("R4 falling edge");
    le_rise();
    check_all("R9 frame shifted while high");
    le_fall();
  endtask

  initial begin
    for (int k = 0; k < 4; k++) exp_r[k] = '0;
    wait_clk(5);
    rst_n = 1;
    wait_clk(5);
    t_reset();
    t_each_addr();
    t_bit_order();
    t_overlong();
    t_short();
    t_le_level();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule